// File: doc/BRIEF.md
# Verify Readout Scrambler and Lock Guard

This block sits in the path that returns memory contents to an external programmer while the part is being verified. It holds a 64-byte key array and a small set of lock bits, both treated as nonvolatile storage that leaves the factory erased (all ones). Each verify read takes a raw memory byte and an address. The block decides, from the current lock level, whether the byte may be shown at all. It then either passes the byte through or scrambles it with one key byte.

Key bytes and lock bits are written by programming requests. A programming request can only clear bits. The only way to set bits again is a mass-erase command, which restores the key array and the lock bits to the erased state. That erased state leaves reads unscrambled and unlocked. The key array counts as in use as soon as any one of its bytes differs from FFh.

Top module: `verify_readout_guard`

## Requirements
- R1: After reset, rd_valid_o is 0 and rd_data_o is FFh. The key array and lock bits are erased, so the first read returns the memory byte unchanged.
- R2: With every key byte at FFh and the lock level below the blocking level, rd_data_o equals the mem_data_i sampled with the read.
- R3: A key write sets the addressed key byte to its old value AND key_data_i, so programming only turns bits from 1 to 0.
- R4: Once any key byte differs from FFh, a permitted read returns the bitwise XNOR of the memory byte and the selected key byte, that is ~(mem ^ key).
- R5: The key byte used is the one indexed by rd_addr_i[5:0]. Higher address bits have no effect on which key byte is chosen.
- R6: A lock write ANDs lock_data_i into the lock bits. The lock level never drops except through a mass erase.
- R7: The lock level is 0 when all lock bits are 1. Otherwise it is one plus the index of the highest cleared bit. At level 2 or above, every read returns FFh. Levels 0 and 1 allow reads.
- R8: Mass erase sets all lock bits and all key bytes back to ones. It wins over a key or lock write in the same cycle.
- R9: A read issued in the same cycle as a key write sees the old key value. Reads issued in later cycles see the new value.
- R10: rd_valid_o is high exactly in the cycle after rd_en_i was high. rd_data_o holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Verify read request |
| rd_addr_i | input | ADDR_W | Verify read address |
| mem_data_i | input | 8 | Raw memory byte for this read |
| key_wr_i | input | 1 | Key byte programming request |
| key_idx_i | input | 6 | Key byte index to program |
| key_data_i | input | 8 | Key programming data (clears zero bits) |
| lock_wr_i | input | 1 | Lock bit programming request |
| lock_data_i | input | LOCK_BITS | Lock programming data (clears zero bits) |
| erase_i | input | 1 | Mass erase command |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Presented verify byte |

## Verification
The read path is tried with an erased key array, to show pure pass-through. It is then tried with single key bytes programmed to distinct patterns, so that XNOR output cannot be mistaken for XOR, inversion or pass-through. Addresses that differ only above bit 5 are read to separate correct key indexing from use of the full address. A read issued in the same cycle as a key write separates old-key from new-key timing. Lock bits are cleared one at a time and then rewritten to ones. This tells the allowed level apart from the blocking level and shows that levels never fall without an erase. An erase issued together with writes shows that erase takes priority.

// File: rtl/vg_pkg.sv
package vg_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] vg_byte_t;
  localparam vg_byte_t BYTE_BLANK = '1;

  function automatic vg_byte_t vg_scramble(vg_byte_t mem, vg_byte_t key);
    return ~(mem ^ key);
  endfunction
endpackage

// File: rtl/vg_key_array.sv
module vg_key_array
  import vg_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  vg_byte_t wr_data_i,
  input  logic     erase_i,
  input  logic [IW-1:0] rd_idx_i,
  output vg_byte_t rd_key_o,
  output logic     active_o
);
  vg_byte_t key_q [DEPTH];
  logic [DEPTH-1:0] not_blank;

  // reset models a blank part; erase dominates writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) key_q[i] <= BYTE_BLANK;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) key_q[i] <= BYTE_BLANK;
    end else if (wr_i) begin
      key_q[wr_idx_i] <= key_q[wr_idx_i] & wr_data_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    assign not_blank[g] = ~&key_q[g];
  end

  assign active_o = |not_blank;
  assign rd_key_o = key_q[rd_idx_i];
endmodule

// File: rtl/vg_lock_ctrl.sv
module vg_lock_ctrl #(
  parameter int unsigned LOCK_BITS = 3,
  localparam int unsigned LVW = $clog2(LOCK_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [LOCK_BITS-1:0] wr_data_i,
  input  logic                 erase_i,
  output logic [LVW-1:0]       level_o
);
  logic [LOCK_BITS-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= '1;
    else if (erase_i) lock_q <= '1;
    else if (wr_i)    lock_q <= lock_q & wr_data_i;
  end

  // level = 1 + index of highest programmed (zero) bit
  always_comb begin
    level_o = '0;
    for (int i = 0; i < LOCK_BITS; i++)
      if (!lock_q[i]) level_o = LVW'(i + 1);
  end
endmodule

// File: rtl/verify_readout_guard.sv
module verify_readout_guard
  import vg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned KEY_DEPTH   = 64,
  parameter int unsigned LOCK_BITS   = 3,
  parameter int unsigned BLOCK_LEVEL = 2,
  localparam int unsigned KIW = $clog2(KEY_DEPTH),
  localparam int unsigned LVW = $clog2(LOCK_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic [7:0]           mem_data_i,
  input  logic                 key_wr_i,
  input  logic [KIW-1:0]       key_idx_i,
  input  logic [7:0]           key_data_i,
  input  logic                 lock_wr_i,
  input  logic [LOCK_BITS-1:0] lock_data_i,
  input  logic                 erase_i,
  output logic                 rd_valid_o,
  output logic [7:0]           rd_data_o
);
  vg_byte_t       sel_key;
  logic           enc_active;
  logic [LVW-1:0] lock_level;
  logic           rd_blocked;
  vg_byte_t       rd_next;

  vg_key_array #(.DEPTH(KEY_DEPTH)) i_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (key_wr_i),
    .wr_idx_i  (key_idx_i),
    .wr_data_i (key_data_i),
    .erase_i   (erase_i),
    .rd_idx_i  (rd_addr_i[KIW-1:0]),
    .rd_key_o  (sel_key),
    .active_o  (enc_active)
  );

  vg_lock_ctrl #(.LOCK_BITS(LOCK_BITS)) i_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (lock_wr_i),
    .wr_data_i (lock_data_i),
    .erase_i   (erase_i),
    .level_o   (lock_level)
  );

  assign rd_blocked = int'(lock_level) >= int'(BLOCK_LEVEL);

  always_comb begin
    if (rd_blocked)      rd_next = BYTE_BLANK;
    else if (enc_active) rd_next = vg_scramble(mem_data_i, sel_key);
    else                 rd_next = mem_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= BYTE_BLANK;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_next;
    end
  end
endmodule

// File: rtl/vg_checker.sv
module vg_checker #(
  parameter int unsigned LVW = 2,
  parameter int unsigned BLOCK_LEVEL = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rd_en_i,
  input logic [7:0]     mem_data_i,
  input logic           erase_i,
  input logic           rd_valid_o,
  input logic [7:0]     rd_data_o,
  input logic           enc_active,
  input logic [LVW-1:0] lock_level
);
  p_valid_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  p_valid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && $stable(rd_data_o)));
  p_blocked_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && int'(lock_level) >= int'(BLOCK_LEVEL)) |=> rd_data_o == 8'hFF);
  p_passthru_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !enc_active && int'(lock_level) < int'(BLOCK_LEVEL))
      |=> rd_data_o == $past(mem_data_i));
  p_lock_ratchet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> lock_level >= $past(lock_level));
  p_erase_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (lock_level == '0 && !enc_active));
endmodule

bind verify_readout_guard vg_checker #(.LVW(LVW), .BLOCK_LEVEL(BLOCK_LEVEL)) i_vg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .mem_data_i (mem_data_i),
  .erase_i    (erase_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .enc_active (enc_active),
  .lock_level (lock_level)
);

// File: tb/test_verify_readout_guard.sv
`timescale 1ns/1ps
module test_verify_readout_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rd_addr_i = '0;
  logic [7:0]  mem_data_i = '0;
  logic        key_wr_i = 1'b0;
  logic [5:0]  key_idx_i = '0;
  logic [7:0]  key_data_i = '0;
  logic        lock_wr_i = 1'b0;
  logic [2:0]  lock_data_i = '1;
  logic        erase_i = 1'b0;
  logic        rd_valid_o;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] key_m [64];
  logic [2:0] lock_m;

  always #5 clk_i = ~clk_i;

  verify_readout_guard i_verify_readout_guard (.*);

  function automatic int lvl_m();
    int l = 0;
    for (int i = 0; i < 3; i++) if (!lock_m[i]) l = i + 1;
    return l;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a, logic [7:0] m);
    logic act = 1'b0;
    for (int i = 0; i < 64; i++) if (key_m[i] != 8'hFF) act = 1'b1;
    if (lvl_m() >= 2) return 8'hFF;
    if (act) return ~(m ^ key_m[a[5:0]]);
    return m;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_erase();
    for (int i = 0; i < 64; i++) key_m[i] = 8'hFF;
    lock_m = '1;
  endtask

  task automatic do_read(string req, logic [15:0] a, logic [7:0] m);
    logic [7:0] e;
    e = exp_read(a, m);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = a; mem_data_i = m;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk({req, " valid"}, {7'd0, rd_valid_o}, 8'd1);
    chk(req, rd_data_o, e);
  endtask

  task automatic prog_key(logic [5:0] idx, logic [7:0] d);
    @(negedge clk_i);
    key_wr_i = 1'b1; key_idx_i = idx; key_data_i = d;
    @(negedge clk_i);
    key_wr_i = 1'b0;
    key_m[idx] = key_m[idx] & d;
  endtask

  task automatic prog_lock(logic [2:0] d);
    @(negedge clk_i);
    lock_wr_i = 1'b1; lock_data_i = d;
    @(negedge clk_i);
    lock_wr_i = 1'b0;
    lock_m = lock_m & d;
  endtask

  task automatic mass_erase();
    @(negedge clk_i);
    erase_i = 1'b1;
    @(negedge clk_i);
    erase_i = 1'b0;
    model_erase();
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {7'd0, rd_valid_o}, 8'd0);
    chk("R1 reset data", rd_data_o, 8'hFF);
    do_read("R1 first read", 16'h0012, 8'h5A);
  endtask

  task automatic t_blank();
    do_read("R2 blank a", 16'h0000, 8'h00);
    do_read("R2 blank b", 16'hBEEF, 8'hC3);
    @(negedge clk_i);
    chk("R10 idle valid", {7'd0, rd_valid_o}, 8'd0);
    chk("R10 hold data", rd_data_o, 8'hC3);
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    key_wr_i = 1'b1; key_idx_i = 6'd5; key_data_i = 8'h00;
    rd_en_i = 1'b1; rd_addr_i = 16'h0005; mem_data_i = 8'h3C;
    @(negedge clk_i);
    key_wr_i = 1'b0; rd_en_i = 1'b0;
    chk("R9 old key", rd_data_o, 8'h3C);
    key_m[5] = 8'h00;
    do_read("R9 new key", 16'h0005, 8'h3C);
  endtask

  task automatic t_encrypt();
    prog_key(6'd10, 8'hA5);
    do_read("R4 xnor", 16'h000A, 8'h0F);
    chk("R4 xnor literal", rd_data_o, 8'h55);
    do_read("R4 blank key byte", 16'h0011, 8'h96);
    prog_key(6'd10, 8'hF0);
    do_read("R3 and program", 16'h000A, 8'h00);
    chk("R3 literal", rd_data_o, 8'h5F);
    prog_key(6'd10, 8'hFF);
    do_read("R3 no set back", 16'h000A, 8'h00);
  endtask

  task automatic t_alias();
    prog_key(6'd63, 8'h3C);
    do_read("R5 idx 63", 16'h003F, 8'h12);
    do_read("R5 alias high", 16'hFFFF, 8'h12);
    chk("R5 alias literal", rd_data_o, 8'hD1);
    do_read("R5 alias 0x40", 16'h0040, 8'h77);
  endtask

  task automatic t_lock();
    prog_lock(3'b110);
    do_read("R7 level1 allowed", 16'h0003, 8'hA0);
    prog_lock(3'b101);
    do_read("R7 level2 blocked", 16'h0003, 8'hA0);
    chk("R7 blocked literal", rd_data_o, 8'hFF);
    prog_lock(3'b111);
    do_read("R6 stays blocked", 16'h0003, 8'h11);
    prog_lock(3'b011);
    do_read("R7 level3 blocked", 16'h0020, 8'h00);
  endtask

  task automatic t_erase();
    @(negedge clk_i);
    erase_i = 1'b1; key_wr_i = 1'b1; key_idx_i = 6'd1; key_data_i = 8'h00;
    lock_wr_i = 1'b1; lock_data_i = 3'b000;
    @(negedge clk_i);
    erase_i = 1'b0; key_wr_i = 1'b0; lock_wr_i = 1'b0; lock_data_i = '1;
    model_erase();
    do_read("R8 erase wins key", 16'h0001, 8'h6B);
    chk("R8 literal", rd_data_o, 8'h6B);
    prog_key(6'd2, 8'h0F);
    mass_erase();
    do_read("R8 erase clears", 16'h0002, 8'h44);
  endtask

  initial begin
    model_erase();
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_blank();
    t_same_cycle();
    t_encrypt();
    t_alias();
    t_lock();
    t_erase();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule